// File: doc/BRIEF.md
# Interrupt Pending-State Clear Register Bank

This block holds the pending and active state of a set of interrupts and gives software a bank of 32-bit registers for reading and clearing the pending state. Each register covers 32 consecutive interrupt IDs. Reading a register returns one bit per interrupt, set when that interrupt is pending, whether or not it is also active. Writing ones removes pending state. The active state is kept, so an interrupt that is both active and pending becomes just active.

Pending state has three sources. An edge-configured line sets a latch on its rising edge. A level-configured line counts as pending for as long as it is high. A software set-pulse latches pending on any interrupt. A clear write can only empty the latch, so a level line that stays high keeps its interrupt pending. Interrupt IDs 0 to 15 are reserved for software-generated interrupts, and this port can read them but cannot clear them. When security is enabled, a per-interrupt secure-group attribute hides interrupts from non-secure accesses unless a per-interrupt grant allows the access.

The register port is a valid/ready request channel paired with a valid/ready response channel. Every accepted request, read or write, returns exactly one response beat, and a write's response carries zero. A request is accepted only when no response is waiting, or when the waiting response is taken in the same cycle. A response that is not taken holds its data unchanged, and the request channel stays blocked until the response is taken.

Top module: `irq_clrpend_bank`

## Requirements
- R1: Register n sits at byte address 0x280 + 4n, and bit x of that register maps to interrupt ID 32n + x.
- R2: A read returns 1 in each bit whose interrupt is pending, including one that is active and pending, and 0 for each bit whose interrupt is not pending.
- R3: Writing 0 to a bit leaves that interrupt's state unchanged.
- R4: Writing 1 to a bit removes latched pending state. Pending becomes inactive, active-and-pending becomes active, and the active bit is never changed by a register write.
- R5: Bits for IDs 0 to 15 read their pending state, and writes to them have no effect.
- R6: A level-configured interrupt is pending while its line is high, and a clear write cannot change that. A clear write does remove pending that was latched by a software set-pulse.
- R7: Bits for IDs at or above NUM_IRQ read zero and ignore writes. An access to an address outside the bank, or to an address that is not word-aligned, reads zero and changes nothing.
- R8: With sec_en high, a non-secure access sees zero for, and cannot clear, an interrupt whose grp_secure bit is 1.
- R9: A set ns_grant bit lets non-secure accesses read and clear that secure-group interrupt.
- R10: After reset, every interrupt is neither pending nor active.
- R11: A rising edge on an edge-configured line makes the interrupt pending on the next cycle. If a clear write lands in the same cycle as that edge, the interrupt stays pending.
- R12: While rsp_valid is high and rsp_ready is low, rsp_rdata holds its value and req_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_line | input | N | Interrupt input lines, one per ID |
| irq_level | input | N | 1 = the ID is level-configured, 0 = edge-configured |
| sw_set | input | N | Software set-pending pulse, one per ID |
| act_set | input | N | Marks the ID as active |
| act_clr | input | N | Marks the ID as no longer active |
| grp_secure | input | N | 1 = the ID belongs to a secure group |
| ns_grant | input | N | 1 = non-secure accesses may reach this secure-group ID |
| sec_en | input | 1 | Security filtering enable |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data; a 1 in a bit clears that interrupt |
| req_secure | input | 1 | 1 = secure access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_rdata | output | 32 | Read data; zero for writes |
| pending | output | N | Pending state per ID |
| active | output | N | Active state per ID |

## Verification
The assertions take irq_level as fixed for the whole run and assume that IDs 0 to 15 are edge-configured. If either assumption failed, a falling pending bit could not be blamed on a register write. The bench sets those configuration inputs once before reset and never changes them. It changes lines, pulses and requests only on the falling clock edge, so each rising edge sees one clean set of inputs. Back-pressure is applied only by holding rsp_ready low while a response is waiting, which is exactly the case the hold and blocking properties cover.

// File: rtl/irq_clrpend_pkg.sv
`timescale 1ns/1ps
package irq_clrpend_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ADDR_W   = 12;
  localparam logic [ADDR_W-1:0] BANK_BASE = 12'h280;
  localparam int unsigned SGI_LAST = 15;
endpackage

// File: rtl/irq_pend_cell.sv
`timescale 1ns/1ps
module irq_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic is_level,
  input  logic sw_set,
  input  logic clr,
  input  logic act_set,
  input  logic act_clr,
  output logic pending,
  output logic active
);
  logic prev_q, latch_q, act_q;
  logic rise;

  // edges only latch for edge-configured inputs
  assign rise = line & ~prev_q & ~is_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
      act_q   <= 1'b0;
    end else begin
      prev_q  <= line;
      // a new edge or set-pulse wins over a clear in the same cycle
      latch_q <= (latch_q & ~clr) | rise | sw_set;
      if (act_set)      act_q <= 1'b1;
      else if (act_clr) act_q <= 1'b0;
    end
  end

  assign pending = latch_q | (is_level & line);
  assign active  = act_q;
endmodule

// File: rtl/irq_addr_decode.sv
`timescale 1ns/1ps
module irq_addr_decode
  import irq_clrpend_pkg::*;
#(
  parameter int unsigned NREG  = 2,
  parameter int unsigned IDX_W = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-3:0] word;

  assign offset = addr - BANK_BASE;
  assign word   = offset[ADDR_W-1:2];
  assign hit    = (addr >= BANK_BASE) && (offset[1:0] == 2'b00) &&
                  (int'(word) < int'(NREG));
  assign idx    = word[IDX_W-1:0];
endmodule

// File: rtl/irq_clrpend_bank.sv
`timescale 1ns/1ps
module irq_clrpend_bank
  import irq_clrpend_pkg::*;
#(
  parameter int unsigned CFG_LINES = 1,
  parameter int unsigned NUM_IRQ   = 56,
  localparam int unsigned NREG     = CFG_LINES + 1,
  localparam int unsigned N        = NREG * WORD_W,
  localparam int unsigned IDX_W    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_line,
  input  logic [N-1:0]      irq_level,
  input  logic [N-1:0]      sw_set,
  input  logic [N-1:0]      act_set,
  input  logic [N-1:0]      act_clr,
  input  logic [N-1:0]      grp_secure,
  input  logic [N-1:0]      ns_grant,
  input  logic              sec_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic              req_secure,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic [N-1:0]      pending,
  output logic [N-1:0]      active
);
  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic             acc, wr_fire;
  logic [N-1:0]     allow, clr, vis;
  logic [WORD_W-1:0] rd_word;

  irq_addr_decode #(.NREG(NREG), .IDX_W(IDX_W)) u_dec (
    .addr(req_addr), .hit(dec_hit), .idx(dec_idx)
  );

  assign req_ready = ~rsp_valid | rsp_ready;
  assign acc       = req_valid & req_ready;
  assign wr_fire   = acc & req_write & dec_hit;

  for (genvar i = 0; i < N; i++) begin : g_slot
    localparam int unsigned RIDX = i / WORD_W;
    localparam int unsigned BIT  = i % WORD_W;
    localparam bit WRITABLE      = (i > SGI_LAST);

    assign allow[i] = ~sec_en | req_secure | ~grp_secure[i] | ns_grant[i];
    assign clr[i]   = wr_fire & (dec_idx == IDX_W'(RIDX)) & req_wdata[BIT] &
                      allow[i] & WRITABLE;

    if (i < NUM_IRQ) begin : g_impl
      irq_pend_cell u_cell (
        .clk(clk), .rst_n(rst_n), .line(irq_line[i]), .is_level(irq_level[i]),
        .sw_set(sw_set[i]), .clr(clr[i]), .act_set(act_set[i]),
        .act_clr(act_clr[i]), .pending(pending[i]), .active(active[i])
      );
    end else begin : g_void
      assign pending[i] = 1'b0;
      assign active[i]  = 1'b0;
    end
  end

  assign vis = pending & allow;

  always_comb begin
    rd_word = '0;
    for (int r = 0; r < int'(NREG); r++)
      if (dec_idx == IDX_W'(r)) rd_word = vis[r*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= (!req_write && dec_hit) ? rd_word : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_clrpend_chk.sv
`timescale 1ns/1ps
module irq_clrpend_chk #(
  parameter int unsigned N       = 64,
  parameter int unsigned NUM_IRQ = 56
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irq_line,
  input logic [N-1:0] irq_level,
  input logic [N-1:0] act_clr,
  input logic         req_valid,
  input logic         req_ready,
  input logic         req_write,
  input logic         rsp_valid,
  input logic         rsp_ready,
  input logic [31:0]  rsp_rdata,
  input logic [N-1:0] pending,
  input logic [N-1:0] active
);
  // R12
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  // R12
  req_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_id
    // R11
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_level[i] && irq_line[i] && !$past(irq_line[i]) |=> pending[i]);
    // R6
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_level[i] && irq_line[i] |-> pending[i]);
    // R4
    clr_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_level[i] && !$past(req_valid && req_ready && req_write) |-> !$fell(pending[i]));
    // R4
    active_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(act_clr[i]) |-> !$fell(active[i]));
    if (i < 16) begin : g_sgi
      // R5
      sgi_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_level[i] |-> !$fell(pending[i]));
    end
  end
endmodule

bind irq_clrpend_bank irq_clrpend_chk #(.N(N), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .irq_level(irq_level),
  .act_clr(act_clr), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .pending(pending), .active(active)
);

// File: tb/sim_irq_clrpend_bank.sv
`timescale 1ns/1ps
module sim_irq_clrpend_bank;
  localparam int N = 64;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] irq_line = '0, irq_level = '0, sw_set = '0, act_set = '0, act_clr = '0;
  logic [N-1:0] grp_secure = '0, ns_grant = '0, pending, active;
  logic sec_en = 0, req_valid = 0, req_write = 0, req_secure = 0, rsp_ready = 1;
  logic req_ready, rsp_valid;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rsp_rdata, rd;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_clrpend_bank u0 (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [11:0] a, logic [31:0] d, bit sec, output logic [31:0] r);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_secure = sec;
    @(negedge clk);
    req_valid = 0;
    r = rsp_rdata;
  endtask

  task automatic edge_pulse(int id);
    @(negedge clk); irq_line[id] = 1;
    @(negedge clk); irq_line[id] = 0;
  endtask

  task automatic swpulse(int id);
    @(negedge clk); sw_set[id] = 1;
    @(negedge clk); sw_set[id] = 0;
  endtask

  task automatic t_reset();
    check("R10 pending", pending, 64'h0);
    check("R10 active", active, 64'h0);
  endtask

  task automatic t_edge_clear();
    edge_pulse(33);
    check("R11 edge sets", pending[33], 1);
    access(0, 12'h284, 0, 1, rd);
    check("R1 R2 read id33", rd, 32'h2);
    access(1, 12'h284, 32'h0, 1, rd);
    check("R3 zero write", pending[33], 1);
    access(1, 12'h280, 32'h2, 1, rd);
    check("R1 wrong reg", pending[33], 1);
    access(1, 12'h284, 32'h2, 1, rd);
    check("R4 cleared", pending[33], 0);
  endtask

  task automatic t_active();
    edge_pulse(34);
    @(negedge clk); act_set[34] = 1;
    @(negedge clk); act_set[34] = 0;
    access(0, 12'h284, 0, 1, rd);
    check("R2 active+pending reads 1", rd[2], 1);
    access(1, 12'h284, 32'h4, 1, rd);
    check("R4 pending gone", pending[34], 0);
    check("R4 active kept", active[34], 1);
  endtask

  task automatic t_sgi();
    swpulse(5);
    access(0, 12'h280, 0, 1, rd);
    check("R5 sgi read", rd[5], 1);
    access(1, 12'h280, 32'hFFFF, 1, rd);
    check("R5 sgi write ignored", pending[5], 1);
  endtask

  task automatic t_level();
    @(negedge clk); irq_line[40] = 1;
    @(negedge clk);
    access(1, 12'h284, 32'h100, 1, rd);
    check("R6 level held", pending[40], 1);
    @(negedge clk); irq_line[40] = 0;
    @(negedge clk);
    check("R6 level drops", pending[40], 0);
    swpulse(41);
    access(1, 12'h284, 32'h200, 1, rd);
    check("R6 sw latch cleared", pending[41], 0);
    @(negedge clk); irq_line[42] = 1;
    swpulse(42);
    access(1, 12'h284, 32'h400, 1, rd);
    @(negedge clk); irq_line[42] = 0;
    @(negedge clk);
    check("R6 latch gone after line drop", pending[42], 0);
  endtask

  task automatic t_unimpl();
    edge_pulse(35);
    access(0, 12'h284, 0, 1, rd);
    check("R7 upper bits zero", rd[31:24], 0);
    access(0, 12'h288, 0, 1, rd);
    check("R7 out of range read", rd, 0);
    access(0, 12'h285, 0, 1, rd);
    check("R7 misaligned read", rd, 0);
    access(1, 12'h288, 32'hFFFF_FFFF, 1, rd);
    access(1, 12'h287, 32'hFFFF_FFFF, 1, rd);
    check("R7 stray write ignored", pending[35], 1);
    access(1, 12'h284, 32'h8, 1, rd);
  endtask

  task automatic t_secure();
    @(negedge clk); sec_en = 1;
    edge_pulse(48);
    edge_pulse(50);
    access(0, 12'h284, 0, 0, rd);
    check("R8 ns read hidden", rd[16], 0);
    check("R9 ns read granted", rd[18], 1);
    access(1, 12'h284, 32'h5_0000, 0, rd);
    check("R8 ns write ignored", pending[48], 1);
    check("R9 ns write granted", pending[50], 0);
    access(0, 12'h284, 0, 1, rd);
    check("R8 secure read", rd[16], 1);
    access(1, 12'h284, 32'h1_0000, 1, rd);
    check("R8 secure clear", pending[48], 0);
  endtask

  task automatic t_race();
    @(negedge clk);
    irq_line[36] = 1;
    req_valid = 1; req_write = 1; req_addr = 12'h284; req_wdata = 32'h10; req_secure = 1;
    @(negedge clk);
    req_valid = 0; irq_line[36] = 0;
    check("R11 edge wins over clear", pending[36], 1);
    access(1, 12'h284, 32'h10, 1, rd);
    check("R11 later clear", pending[36], 0);
  endtask

  task automatic t_backpressure();
    logic [31:0] first;
    @(negedge clk); rsp_ready = 0;
    access(0, 12'h280, 0, 1, rd);
    first = rsp_rdata;
    @(negedge clk); @(negedge clk);
    check("R12 valid held", rsp_valid, 1);
    check("R12 data held", rsp_rdata, first);
    check("R12 req blocked", req_ready, 0);
    check("R12 data value", first[5], 1);
    rsp_ready = 1;
    @(negedge clk);
    check("R12 released", rsp_valid, 0);
  endtask

  initial begin
    irq_level[47:40] = '1;
    grp_secure[51:48] = '1;
    ns_grant[50] = 1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_edge_clear();
    t_active();
    t_sgi();
    t_level();
    t_unimpl();
    t_secure();
    t_race();
    t_backpressure();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule